// File: doc/BRIEF.md
# Frequency Watchdog Timer

This block watches for a system that has stopped responding and, when it has, pulls the clock configuration back to a known safe setting. Software keeps the watchdog quiet by writing to either of its two registers. Every such write is a kick that restarts the countdown. If no kick arrives within the programmed number of timeout units, the block expires. On expiry it pulses an active-low system reset, latches a sticky alarm flag, and asserts a frequency-select override that carries a programmable 5-bit safe-frequency code to the clock configuration logic. The safe code uses the same encoding as the main frequency-select field.

A timeout unit is built from a prescaled tick input. An internal prescaler counts `TICKS_PER_UNIT` tick pulses per unit. With a 1 ms tick and the default of 290, one unit is 290 ms, and the reset count of 8 gives about 2.3 s. A simulation can set a short unit. The enable comes from a strap level captured during reset until software first writes the control register. After that, the written bit decides.

The register map has two locations, chosen by a 1-bit select. Select 0 is the 8-bit timeout count. Select 1 is the control byte: bit 0 is enable, bit 1 is alarm, bits 6:2 are the safe-frequency code, and bit 7 reads 0. Reads are combinational.

Top module: `freq_watchdog`

## Requirements
- R1: After reset the count register reads 8 and the safe code reads 0. The alarm is 0, the override valid is 0 and `sys_rst_n` is 1. With the strap low, control reads 0x00.
- R2: While enabled, expiry occurs after max(count,1) × `TICKS_PER_UNIT` tick pulses counted from the last kick. A count of 0 behaves as 1.
- R3: The effective enable, read back in control bit 0, is the strap level captured during reset until the first control write. From then on it is the written bit 0.
- R4: Expiry sets the alarm (control bit 1). The alarm stays set through later kicks and while counting is disabled.
- R5: `fsel_ovr_valid` equals the alarm. `fsel_ovr_code` equals the safe code held in control bits 6:2.
- R6: `sys_rst_n` goes low in the cycle after expiry and stays low for exactly `RST_PULSE_CYCLES` cycles.
- R7: Any write to either register reloads the countdown with the count value, including a count being written in that same cycle, and restarts the prescaler.
- R8: A write that lands on the same clock edge as the final unit of the countdown wins. No expiry occurs, and a full new period starts.
- R9: With the effective enable at 0 the countdown halts. No expiry or reset pulse follows, and a latched alarm is left unchanged.
- R10: Only a control write with bit 1 = 0 clears the alarm. A write with bit 1 = 1 never sets it.
- R11: Only cycles with `tick_in` high advance the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_wd_en | input | 1 | Enable level captured while in reset |
| tick_in | input | 1 | Prescaler tick, one cycle wide |
| wr_en | input | 1 | Register write strobe (also a kick) |
| wr_sel | input | 1 | Write target: 0 count, 1 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 count, 1 control |
| rd_data | output | 8 | Read data |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wd_alarm | output | 1 | Sticky alarm status |
| fsel_ovr_valid | output | 1 | Frequency-select override active |
| fsel_ovr_code | output | 5 | Safe frequency-select code |

## Verification
A software kick and the final unit tick of the countdown can fall on the same clock edge. The bench provokes this by counting edges from a known kick and placing a second write exactly on the edge where expiry would otherwise occur. It judges the result by seeing that the alarm and the reset stay idle, and that expiry then happens one full period after that write. Clearing the alarm is also a write, so an alarm clear and an expiry can never coincide. The bench confirms this indirectly through the same kick rule.

// File: rtl/fwdt_pkg.sv
// Package: shared constants and the register select encoding for the
// frequency watchdog. Assumes an 8-bit register data path.
package fwdt_pkg;
    localparam int REG_W         = 8;
    localparam int CODE_W        = 5;
    localparam int COUNT_RESET   = 8;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_ALM_BIT  = 1;
    localparam int CTRL_CODE_LSB = 2;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CTRL  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/fwdt_prescaler.sv
// Prescaler: divides tick_in pulses into timeout units and emits a
// one-cycle unit strobe. Assumes TICKS_PER_UNIT >= 1; it is cleared by a
// restart (kick) and while the watchdog is not running.
module fwdt_prescaler #(
    parameter int TICKS_PER_UNIT = 290
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick_in,
    output logic unit_stb
);
    localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_UNIT - 1);

    logic [PW-1:0] pre_q;

    // Strobe on the tick that completes a unit.
    always_comb begin
        unit_stb = run && !restart && tick_in && (pre_q == LAST);
    end

    // Count ticks within the current unit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q <= '0;
        end else if (tick_in) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);                                                     // R11
    AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick_in) |=> $stable(pre_q));                  // R11
endmodule

// File: rtl/fwdt_countdown.sv
// Countdown: holds the units left before expiry, reloads on a kick and
// on expiry, and flags expiry combinationally. Assumes a kick takes
// priority over the unit strobe in the same cycle; a count of 0 acts as 1.
module fwdt_countdown #(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               kick,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               unit_stb,
    output logic               expire
);
    localparam logic [COUNT_W-1:0] ONE      = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] RST_LOAD = COUNT_W'(fwdt_pkg::COUNT_RESET);

    logic [COUNT_W-1:0] rem_q;
    logic               last_unit;

    // Expiry: the final unit arrives and no kick competes with it.
    always_comb begin
        last_unit = (rem_q <= ONE);
        expire    = unit_stb && !kick && last_unit;
    end

    // Remaining-unit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= RST_LOAD;
        end else if (kick) begin
            rem_q <= load_val;
        end else if (unit_stb) begin
            rem_q <= last_unit ? load_val : rem_q - ONE;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick) |=> $stable(rem_q));                                // R9
    AST_EXPIRE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> run);                                                    // R9
    AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (rem_q == $past(load_val)));                               // R7
endmodule

// File: rtl/fwdt_regs.sv
// Register file: count and control registers, strap capture, sticky
// alarm, kick generation and read mux. Assumes COUNT_W <= REG_W and that
// every write, to either location, is a kick.
module fwdt_regs #(
    parameter int COUNT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        strap_en,
    input  logic                        wr_en,
    input  logic                        wr_sel,
    input  logic [fwdt_pkg::REG_W-1:0]  wr_data,
    input  logic                        rd_sel,
    input  logic                        expire,
    output logic [fwdt_pkg::REG_W-1:0]  rd_data,
    output logic                        run,
    output logic                        kick,
    output logic [COUNT_W-1:0]          load_val,
    output logic                        alarm,
    output logic [fwdt_pkg::CODE_W-1:0] safe_code
);
    import fwdt_pkg::*;

    localparam logic [COUNT_W-1:0] CNT_INIT = COUNT_W'(COUNT_RESET);

    logic [COUNT_W-1:0] cnt_q;
    logic               en_q;
    logic               en_set_q;
    logic               strap_q;
    logic               alarm_q;
    logic [CODE_W-1:0]  safe_q;
    logic               wr_cnt;
    logic               wr_ctrl;

    // Decode the write target.
    always_comb begin
        wr_cnt  = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
        wr_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    end

    // Configuration registers and strap capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= CNT_INIT;
            en_q     <= 1'b0;
            en_set_q <= 1'b0;
            strap_q  <= strap_en;
            safe_q   <= '0;
        end else begin
            if (wr_cnt) begin
                cnt_q <= wr_data[COUNT_W-1:0];
            end
            if (wr_ctrl) begin
                en_q     <= wr_data[CTRL_EN_BIT];
                en_set_q <= 1'b1;
                safe_q   <= wr_data[CTRL_CODE_LSB +: CODE_W];
            end
        end
    end

    // Sticky alarm: set by expiry, cleared only by writing 0 to its bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if (expire) begin
            alarm_q <= 1'b1;
        end else if (wr_ctrl && !wr_data[CTRL_ALM_BIT]) begin
            alarm_q <= 1'b0;
        end
    end

    // Effective enable, kick and reload value.
    always_comb begin
        run      = en_set_q ? en_q : strap_q;
        kick     = wr_en;
        load_val = wr_cnt ? wr_data[COUNT_W-1:0] : cnt_q;
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(rd_sel) == SEL_COUNT) begin
            rd_data = REG_W'(cnt_q);
        end else begin
            rd_data[CTRL_EN_BIT]                  = run;
            rd_data[CTRL_ALM_BIT]                 = alarm_q;
            rd_data[CTRL_CODE_LSB +: CODE_W]      = safe_q;
        end
    end

    assign alarm     = alarm_q;
    assign safe_code = safe_q;

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && !(wr_ctrl && !wr_data[CTRL_ALM_BIT])) |=> alarm_q);     // R4
    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_q && !expire) |=> !alarm_q);                                // R10
    AST_EXPIRE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> alarm_q);                                                // R4
endmodule

// File: rtl/fwdt_rst_pulse.sv
// Reset pulse generator: drives an active-low output for PULSE_CYCLES
// cycles after each fire strobe; a new fire restarts the pulse.
// Assumes PULSE_CYCLES >= 1.
module fwdt_rst_pulse #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_out_n
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    logic [CW-1:0] left_q;

    // Cycles of pulse remaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Output is low while cycles remain.
    always_comb begin
        rst_out_n = (left_q == '0);
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !rst_out_n);                                               // R6
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LOAD);                                                    // R6
endmodule

// File: rtl/freq_watchdog.sv
// Top: frequency watchdog. Connects the register file, prescaler,
// countdown and reset pulse, and drives the frequency-select override
// from the sticky alarm. Assumes tick_in is a one-cycle pulse in the clk
// domain and a synchronous active-low reset.
module freq_watchdog #(
    parameter int TICKS_PER_UNIT   = 290,
    parameter int RST_PULSE_CYCLES = 16,
    parameter int COUNT_W          = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        strap_wd_en,
    input  logic                        tick_in,
    input  logic                        wr_en,
    input  logic                        wr_sel,
    input  logic [fwdt_pkg::REG_W-1:0]  wr_data,
    input  logic                        rd_sel,
    output logic [fwdt_pkg::REG_W-1:0]  rd_data,
    output logic                        sys_rst_n,
    output logic                        wd_alarm,
    output logic                        fsel_ovr_valid,
    output logic [fwdt_pkg::CODE_W-1:0] fsel_ovr_code
);
    logic                        run;
    logic                        kick;
    logic [COUNT_W-1:0]          load_val;
    logic                        unit_stb;
    logic                        expire;
    logic                        alarm;
    logic [fwdt_pkg::CODE_W-1:0] safe_code;

    fwdt_regs #(.COUNT_W(COUNT_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_en (strap_wd_en),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .expire   (expire),
        .rd_data  (rd_data),
        .run      (run),
        .kick     (kick),
        .load_val (load_val),
        .alarm    (alarm),
        .safe_code(safe_code)
    );

    fwdt_prescaler #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (kick),
        .tick_in (tick_in),
        .unit_stb(unit_stb)
    );

    fwdt_countdown #(.COUNT_W(COUNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .kick    (kick),
        .load_val(load_val),
        .unit_stb(unit_stb),
        .expire  (expire)
    );

    fwdt_rst_pulse #(.PULSE_CYCLES(RST_PULSE_CYCLES)) pulse_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (expire),
        .rst_out_n(sys_rst_n)
    );

    // Override follows the alarm and carries the programmed safe code.
    always_comb begin
        wd_alarm       = alarm;
        fsel_ovr_valid = alarm;
        fsel_ovr_code  = safe_code;
    end

    AST_KICK_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !expire);                                                 // R8
    AST_RESET_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!sys_rst_n && wd_alarm));                               // R6
endmodule

// File: tb/freq_watchdog_tb_top.sv
module freq_watchdog_tb_top;
    localparam int TPU  = 4;
    localparam int RSTC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b0;
    logic       tick_in = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       sys_rst_n;
    logic       wd_alarm;
    logic       ovr_valid;
    logic [4:0] ovr_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    freq_watchdog #(.TICKS_PER_UNIT(TPU), .RST_PULSE_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_wd_en(strap), .tick_in(tick_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .sys_rst_n(sys_rst_n), .wd_alarm(wd_alarm),
        .fsel_ovr_valid(ovr_valid), .fsel_ovr_code(ovr_code)
    );

    // Vector: [31:24] count, [20:16] safe code, [15:8] wait edges, [0] expected alarm.
    localparam logic [31:0] VEC [0:7] = '{
        32'h01_01_03_00, 32'h01_01_04_01,
        32'h02_0A_07_00, 32'h02_0A_08_01,
        32'h05_1F_13_00, 32'h05_1F_14_01,
        32'h00_11_03_00, 32'h00_11_04_01
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    function automatic logic [7:0] ctrl(input logic en, input logic al, input logic [4:0] c);
        return {1'b0, c, al, en};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int lows;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, d); check("R1 count reset", d, 8);
        rd(1'b1, d); check("R1 ctrl reset", d, 8'h00);
        check("R1 alarm reset", wd_alarm, 0);
        check("R1 valid reset", ovr_valid, 0);
        check("R1 sys_rst_n reset", sys_rst_n, 1);
        // R3: strap low, no write -> never counts
        repeat (50) @(posedge clk);
        #1 check("R3 strap low idle", wd_alarm, 0);

        // Table: R2 R4 R5 R7
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            v = VEC[i];
            wr(1'b1, ctrl(1'b1, 1'b0, v[20:16]));
            wr(1'b0, v[31:24]);
            repeat (int'(v[15:8])) @(posedge clk);
            #1;
            check($sformatf("R2 vec%0d alarm", i), wd_alarm, int'(v[0]));
            check($sformatf("R5 vec%0d valid", i), ovr_valid, int'(v[0]));
            if (v[0]) check($sformatf("R5 vec%0d code", i), ovr_code, int'(v[20:16]));
        end

        // R6: reset pulse length
        wr(1'b1, ctrl(1'b1, 1'b0, 5'h02));
        wr(1'b0, 8'd1);
        repeat (4) @(posedge clk);
        #1 check("R6 alarm at expiry", wd_alarm, 1);
        check("R6 pulse cycle1", sys_rst_n, 0);
        @(posedge clk); #1 check("R6 pulse cycle2", sys_rst_n, 0);
        @(posedge clk); #1 check("R6 pulse cycle3", sys_rst_n, 0);
        @(posedge clk); #1 check("R6 pulse end", sys_rst_n, 1);
        wr(1'b1, ctrl(1'b0, 1'b0, 5'h02));

        // R8 / R7: kick on the final-unit edge
        wr(1'b1, ctrl(1'b1, 1'b0, 5'h0C));
        wr(1'b0, 8'd2);
        repeat (7) @(posedge clk);
        wr(1'b0, 8'd2);
        check("R8 coincident kick alarm", wd_alarm, 0);
        check("R8 coincident kick reset", sys_rst_n, 1);
        repeat (7) @(posedge clk);
        #1 check("R7 new period not yet", wd_alarm, 0);
        @(posedge clk);
        #1 check("R7 new period expiry", wd_alarm, 1);

        // R9: disable halts, alarm kept
        wr(1'b1, ctrl(1'b0, 1'b1, 5'h07));
        repeat (4) @(posedge clk);
        lows = 0;
        for (int c = 0; c < 40; c++) begin
            @(posedge clk); #1;
            if (!sys_rst_n) lows++;
        end
        check("R9 no reset when disabled", lows, 0);
        check("R9 alarm kept", wd_alarm, 1);
        check("R5 code follows reg", ovr_code, 7);
        rd(1'b1, d); check("R9 ctrl readback", d, 8'h1E);

        // R10: alarm clear / no set by software
        wr(1'b1, ctrl(1'b0, 1'b0, 5'h07));
        check("R10 alarm cleared", wd_alarm, 0);
        check("R5 valid drops", ovr_valid, 0);
        wr(1'b1, ctrl(1'b0, 1'b1, 5'h07));
        check("R10 write 1 no set", wd_alarm, 0);
        rd(1'b1, d); check("R10 ctrl readback", d, 8'h1C);

        // R11: tick gating
        @(negedge clk) tick_in = 1'b0;
        wr(1'b1, ctrl(1'b1, 1'b0, 5'h00));
        wr(1'b0, 8'd1);
        repeat (20) @(posedge clk);
        #1 check("R11 no ticks no expiry", wd_alarm, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) tick_in = 1'b1;
            @(negedge clk) tick_in = 1'b0;
            @(negedge clk);
        end
        check("R11 three ticks", wd_alarm, 0);
        @(negedge clk) tick_in = 1'b1;
        @(negedge clk) tick_in = 1'b0;
        check("R11 fourth tick expiry", wd_alarm, 1);
        tick_in = 1'b1;
        wr(1'b1, ctrl(1'b0, 1'b0, 5'h00));

        // R3: strap high enables until first control write
        strap = 1'b1;
        do_reset();
        rd(1'b1, d); check("R3 strap enable readback", d, 8'h01);
        repeat (31) @(posedge clk);
        #1 check("R3 strap run not yet", wd_alarm, 0);
        @(posedge clk);
        #1 check("R3 strap run expiry", wd_alarm, 1);
        wr(1'b1, ctrl(1'b0, 1'b1, 5'h00));
        rd(1'b1, d); check("R3 write overrides strap", d, 8'h02);
        rd(1'b0, d); check("R1 count unchanged", d, 8);

        finish_run();
    end
endmodule